// File: doc/BRIEF.md
# Serial Control Register File

This block is the write-only control port of an audio converter. A host drives three lines: a shift clock, a serial data line and a latch strobe. All three are slow compared with the system clock, so they are brought into the system clock domain and their edges are found there. On each rising edge of the shift clock, one data bit moves into a shift register. On a rising edge of the latch line, the word that was collected is written to one of four mode registers. Two address bits inside the word pick the register.

The block drives the decoded settings as plain outputs:

- per-channel attenuation codes, which change only when the word's load bit asks for it
- soft mute, de-emphasis and the DAC hold (force to bipolar zero)
- input word length and output channel routing
- serial format, word-clock polarity and common attenuation
- system clock ratio, rate multiple, rate family and zero-detect enable

Every setting returns to a defined default on reset. Reserved codes are kept exactly as written. Downstream logic decides what a reserved code means.

Top module: `serctl_regfile`

## Requirements
- R1: After a synchronous reset, the outputs hold these values: att_left = att_right = 8'hFF, mute_en = 0, deemph_en = 0, dac_hold = 0, word_len = 2'b00, out_mode = 4'b1001, fmt_i2s = 0, lr_swap = 0, att_common = 0, sysclk_256 = 0, rate_mult = 2'b00, rate_family = 2'b00 and zero_det_en = 0.
- R2: Data bits are taken MSB first, one on each rising edge of ctl_clk. Nothing changes on the outputs until ctl_latch rises. Shifting a full word without a latch leaves every output unchanged.
- R3: Word bits 10:9 select the target register: 0 is left attenuation, 1 is right attenuation, 2 is playback, 3 is interface. Bits 15:11 have no effect.
- R4: In registers 0 and 1, bits 7:0 are the attenuation code and bit 8 is the load bit. A write with bit 8 = 0 leaves the active code unchanged. A write with bit 8 = 1 makes bits 7:0 the active code.
- R5: Register 2 fields: bit 0 is mute_en, bit 1 is deemph_en, bit 2 is dac_hold, bits 4:3 are word_len (00 = 16, 01 = 20, 10 = 24 bits), and bits 8:5 are out_mode.
- R6: Register 3 fields: bit 0 is fmt_i2s, bit 1 is lr_swap, bit 2 is att_common, bit 3 is sysclk_256 (1 = 256fs, 0 = 384fs), bits 5:4 are rate_mult (00 normal, 01 double, 10 half), bits 7:6 are rate_family (00 = 44.1k, 01 = 48k, 10 = 32k), and bit 8 is zero_det_en.
- R7: While att_common = 1, att_right shows the active left code. When att_common returns to 0, att_right shows the right code that was last loaded.
- R8: On a latch, the last 16 bits received are committed, whatever the number of bits shifted since the previous latch. With fewer than 16 new bits, the older bits fill the upper positions.
- R9: Reserved codes are stored and driven as written. This covers word_len = 11, rate_mult = 11 and rate_family = 11.
- R10: With the default two-stage synchronisers, a latch level that rises before a system clock edge changes the outputs at the third rising edge of the system clock. At the second edge the outputs still hold their old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_clk | input | 1 | Serial shift clock (asynchronous) |
| ctl_data | input | 1 | Serial data, MSB first |
| ctl_latch | input | 1 | Commit strobe, acts on its rising edge |
| att_left | output | 8 | Active left attenuation code |
| att_right | output | 8 | Active right attenuation code, or the left code when att_common = 1 |
| mute_en | output | 1 | Soft mute request |
| deemph_en | output | 1 | De-emphasis enable |
| dac_hold | output | 1 | Force both DACs to bipolar zero |
| word_len | output | 2 | Input word length code |
| out_mode | output | 4 | Output channel routing code |
| fmt_i2s | output | 1 | 1 = I2S input format, 0 = right-justified |
| lr_swap | output | 1 | Word-clock polarity inverted |
| att_common | output | 1 | Left code drives both channels |
| sysclk_256 | output | 1 | 1 = 256fs, 0 = 384fs |
| rate_mult | output | 2 | Sample rate multiple code |
| rate_family | output | 2 | Sample rate family code |
| zero_det_en | output | 1 | Infinite zero detection enable |

## Verification
A level change on any serial line passes through two synchroniser flops and one edge register. The commit therefore reaches the outputs on the third system clock edge after the latch line rises. The bench holds each latch pulse high for four system clocks. It pushes the expected settings into the scoreboard queue only after the pulse has ended, so the monitor compares values that have already settled. A separate check samples on the falling clock edge after the second and after the third rising edge following a latch rise, to pin down the exact cycle of R10. The bench changes data three system clocks before each shift-clock rise, so the data level has settled through its synchroniser by the time the edge is detected.

// File: rtl/serctl_pkg.sv
package serctl_pkg;

    localparam int ATT_W    = 8;
    localparam int ADDR_LO  = 9;
    localparam int ADDR_W   = 2;
    localparam int LOAD_BIT = 8;
    localparam int PAY_W    = 9;
    localparam int KEEP_W   = ADDR_LO + ADDR_W;

    typedef enum logic [1:0] {
        WL_16  = 2'b00,
        WL_20  = 2'b01,
        WL_24  = 2'b10,
        WL_RSV = 2'b11
    } wlen_e;

    typedef enum logic [1:0] {
        RM_NORMAL = 2'b00,
        RM_DOUBLE = 2'b01,
        RM_HALF   = 2'b10,
        RM_RSV    = 2'b11
    } rmult_e;

    typedef enum logic [1:0] {
        RF_44K1 = 2'b00,
        RF_48K  = 2'b01,
        RF_32K  = 2'b10,
        RF_RSV  = 2'b11
    } rfam_e;

    typedef enum logic [1:0] {
        SEL_ATT_L = 2'd0,
        SEL_ATT_R = 2'd1,
        SEL_PLAY  = 2'd2,
        SEL_IFACE = 2'd3
    } regsel_e;

    typedef struct packed {
        logic [3:0] omode;
        wlen_e      wlen;
        logic       hold;
        logic       deemph;
        logic       mute;
    } play_cfg_t;

    typedef struct packed {
        logic   zdet;
        rfam_e  rfam;
        rmult_e rmult;
        logic   sys256;
        logic   common;
        logic   lrswap;
        logic   i2s;
    } iface_cfg_t;

    localparam logic [ATT_W-1:0] ATT_DEFAULT = '1;
    localparam logic [3:0]       OMODE_STEREO = 4'b1001;

    localparam play_cfg_t PLAY_DEFAULT = '{
        omode:  OMODE_STEREO,
        wlen:   WL_16,
        hold:   1'b0,
        deemph: 1'b0,
        mute:   1'b0
    };

    localparam iface_cfg_t IFACE_DEFAULT = '{
        zdet:   1'b0,
        rfam:   RF_44K1,
        rmult:  RM_NORMAL,
        sys256: 1'b0,
        common: 1'b0,
        lrswap: 1'b0,
        i2s:    1'b0
    };

    function automatic regsel_e word_sel(input logic [KEEP_W-1:0] w);
        return regsel_e'(w[ADDR_LO +: ADDR_W]);
    endfunction

    function automatic play_cfg_t unpack_play(input logic [PAY_W-1:0] p);
        play_cfg_t c;
        c.omode  = p[8:5];
        c.wlen   = wlen_e'(p[4:3]);
        c.hold   = p[2];
        c.deemph = p[1];
        c.mute   = p[0];
        return c;
    endfunction

    function automatic iface_cfg_t unpack_iface(input logic [PAY_W-1:0] p);
        iface_cfg_t c;
        c.zdet   = p[8];
        c.rfam   = rfam_e'(p[7:6]);
        c.rmult  = rmult_e'(p[5:4]);
        c.sys256 = p[3];
        c.common = p[2];
        c.lrswap = p[1];
        c.i2s    = p[0];
        return c;
    endfunction

endpackage

// File: rtl/ctl_line_sync.sv
module ctl_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/ctl_rise_det.sv
module ctl_rise_det (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic rise
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= lvl;
    end

    assign rise = lvl & ~prev;
endmodule

// File: rtl/ctl_shifter.sv
module ctl_shifter #(
    parameter int DEPTH = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [DEPTH-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst)           word <= '0;
        else if (shift_en) word <= {word[DEPTH-2:0], bit_in};
    end
endmodule

// File: rtl/ctl_regbank.sv
module ctl_regbank
    import serctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  logic [KEEP_W-1:0] word,
    output logic [ATT_W-1:0]  act_left,
    output logic [ATT_W-1:0]  act_right,
    output play_cfg_t         play,
    output iface_cfg_t        iface
);
    regsel_e          sel;
    logic             load_req;
    logic [PAY_W-1:0] payload;

    assign sel      = word_sel(word);
    assign load_req = word[LOAD_BIT];
    assign payload  = word[PAY_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            act_left  <= ATT_DEFAULT;
            act_right <= ATT_DEFAULT;
            play      <= PLAY_DEFAULT;
            iface     <= IFACE_DEFAULT;
        end else if (commit) begin
            case (sel)
                SEL_ATT_L: if (load_req) act_left  <= word[ATT_W-1:0];
                SEL_ATT_R: if (load_req) act_right <= word[ATT_W-1:0];
                SEL_PLAY:  play  <= unpack_play(payload);
                SEL_IFACE: iface <= unpack_iface(payload);
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/serctl_regfile.sv
module serctl_regfile
    import serctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ctl_clk,
    input  logic       ctl_data,
    input  logic       ctl_latch,
    output logic [7:0] att_left,
    output logic [7:0] att_right,
    output logic       mute_en,
    output logic       deemph_en,
    output logic       dac_hold,
    output logic [1:0] word_len,
    output logic [3:0] out_mode,
    output logic       fmt_i2s,
    output logic       lr_swap,
    output logic       att_common,
    output logic       sysclk_256,
    output logic [1:0] rate_mult,
    output logic [1:0] rate_family,
    output logic       zero_det_en
);
    localparam int N_LINES = 3;
    localparam int N_EDGES = 2;
    localparam int L_CLK   = 0;
    localparam int L_LATCH = 1;
    localparam int L_DATA  = 2;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] sync_lines;
    logic [N_EDGES-1:0] edge_rise;

    assign raw_lines[L_CLK]   = ctl_clk;
    assign raw_lines[L_LATCH] = ctl_latch;
    assign raw_lines[L_DATA]  = ctl_data;

    for (genvar gi = 0; gi < N_LINES; gi++) begin : g_sync
        ctl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst  (rst),
            .din  (raw_lines[gi]),
            .dout (sync_lines[gi])
        );
    end

    for (genvar ge = 0; ge < N_EDGES; ge++) begin : g_edge
        ctl_rise_det u_rise (
            .clk  (clk),
            .rst  (rst),
            .lvl  (sync_lines[ge]),
            .rise (edge_rise[ge])
        );
    end

    logic              shift_pulse;
    logic              commit_pulse;
    logic [KEEP_W-1:0] shift_word;

    assign shift_pulse  = edge_rise[L_CLK];
    assign commit_pulse = edge_rise[L_LATCH];

    ctl_shifter #(.DEPTH(KEEP_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_pulse),
        .bit_in   (sync_lines[L_DATA]),
        .word     (shift_word)
    );

    logic [ATT_W-1:0] act_left;
    logic [ATT_W-1:0] act_right;
    play_cfg_t        play;
    iface_cfg_t       iface;

    ctl_regbank u_bank (
        .clk       (clk),
        .rst       (rst),
        .commit    (commit_pulse),
        .word      (shift_word),
        .act_left  (act_left),
        .act_right (act_right),
        .play      (play),
        .iface     (iface)
    );

    assign att_left    = act_left;
    assign att_right   = iface.common ? act_left : act_right;
    assign mute_en     = play.mute;
    assign deemph_en   = play.deemph;
    assign dac_hold    = play.hold;
    assign word_len    = play.wlen;
    assign out_mode    = play.omode;
    assign fmt_i2s     = iface.i2s;
    assign lr_swap     = iface.lrswap;
    assign att_common  = iface.common;
    assign sysclk_256  = iface.sys256;
    assign rate_mult   = iface.rmult;
    assign rate_family = iface.rfam;
    assign zero_det_en = iface.zdet;
endmodule

// File: rtl/serctl_regfile_chk.sv
module serctl_regfile_chk (
    input logic        clk,
    input logic        rst,
    input logic        commit,
    input logic [10:0] word,
    input logic [7:0]  att_left,
    input logic [7:0]  att_right,
    input logic        mute_en,
    input logic        zero_det_en
);
    AST_RESET_DEFAULT: assert property (@(posedge clk)
        rst |=> (att_left == 8'hFF && att_right == 8'hFF && !mute_en && !zero_det_en)); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !commit |=> ($stable(att_left) && $stable(att_right) && $stable(mute_en) && $stable(zero_det_en))); // R2

    AST_LOAD_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (commit && word[10:9] == 2'd0 && !word[8]) |=> $stable(att_left)); // R4

    AST_LOAD_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (commit && word[10:9] == 2'd0 && word[8]) |=> (att_left == $past(word[7:0]))); // R4

    AST_PLAY_MUTE: assert property (@(posedge clk) disable iff (rst)
        (commit && word[10:9] == 2'd2) |=> (mute_en == $past(word[0]))); // R5

    AST_IFACE_ZDET: assert property (@(posedge clk) disable iff (rst)
        (commit && word[10:9] == 2'd3) |=> (zero_det_en == $past(word[8]))); // R6
endmodule

bind serctl_regfile serctl_regfile_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .commit      (commit_pulse),
    .word        (shift_word),
    .att_left    (att_left),
    .att_right   (att_right),
    .mute_en     (mute_en),
    .zero_det_en (zero_det_en)
);

// File: tb/sim_serctl_regfile.sv
module sim_serctl_regfile;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ctl_clk = 1'b0, ctl_data = 1'b0, ctl_latch = 1'b0;
    logic [7:0] att_left, att_right;
    logic mute_en, deemph_en, dac_hold, fmt_i2s, lr_swap, att_common, sysclk_256, zero_det_en;
    logic [1:0] word_len, rate_mult, rate_family;
    logic [3:0] out_mode;

    always #10 clk = ~clk;

    serctl_regfile u0 (
        .clk(clk), .rst(rst), .ctl_clk(ctl_clk), .ctl_data(ctl_data), .ctl_latch(ctl_latch),
        .att_left(att_left), .att_right(att_right), .mute_en(mute_en), .deemph_en(deemph_en),
        .dac_hold(dac_hold), .word_len(word_len), .out_mode(out_mode), .fmt_i2s(fmt_i2s),
        .lr_swap(lr_swap), .att_common(att_common), .sysclk_256(sysclk_256),
        .rate_mult(rate_mult), .rate_family(rate_family), .zero_det_en(zero_det_en)
    );

    typedef struct {
        string      req;
        logic [7:0] al;
        logic [7:0] ar;
        logic [8:0] play;
        logic [8:0] ifc;
    } exp_t;

    exp_t q[$];
    int total = 0;
    int bad = 0;

    logic [15:0] hist;
    logic [7:0]  m_al, m_ar;
    logic [8:0]  m_play, m_if;

    function automatic logic [15:0] mk(input logic [1:0] a, input logic [8:0] p);
        return {5'b00000, a, p};
    endfunction

    function automatic void model_reset();
        hist   = 16'h0000;
        m_al   = 8'hFF;
        m_ar   = 8'hFF;
        m_play = 9'h120;  // out_mode 1001 in bits 8:5, rest zero
        m_if   = 9'h000;
    endfunction

    function automatic void model_apply(input logic [15:0] w);
        case (w[10:9])
            2'd0: if (w[8]) m_al = w[7:0];
            2'd1: if (w[8]) m_ar = w[7:0];
            2'd2: m_play = w[8:0];
            default: m_if = w[8:0];
        endcase
    endfunction

    function automatic void push(input string req);
        exp_t e;
        e.req  = req;
        e.al   = m_al;
        e.ar   = m_if[2] ? m_al : m_ar;
        e.play = m_play;
        e.ifc  = m_if;
        q.push_back(e);
    endfunction

    // Scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t e;
                logic [8:0] a_play, a_if;
                e = q.pop_front();
                a_play = {out_mode, word_len, dac_hold, deemph_en, mute_en};
                a_if   = {zero_det_en, rate_family, rate_mult, sysclk_256, att_common, lr_swap, fmt_i2s};
                total++;
                if (att_left !== e.al || att_right !== e.ar || a_play !== e.play || a_if !== e.ifc) begin
                    bad++;
                    $display("FAIL %s: actual al=%h ar=%h play=%h if=%h expected al=%h ar=%h play=%h if=%h",
                             e.req, att_left, att_right, a_play, a_if, e.al, e.ar, e.play, e.ifc);
                end
            end
        end
    end

    task automatic send_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk);
            ctl_data = v[i];
            repeat (3) @(negedge clk);
            ctl_clk = 1'b1;
            repeat (3) @(negedge clk);
            ctl_clk = 1'b0;
            hist = {hist[14:0], v[i]};
        end
    endtask

    task automatic latch_word();
        @(negedge clk);
        ctl_latch = 1'b1;
        repeat (4) @(negedge clk);
        ctl_latch = 1'b0;
        repeat (3) @(negedge clk);
        model_apply(hist);
    endtask

    task automatic write_word(input logic [15:0] w, input string req);
        send_bits({16'h0000, w}, 16);
        latch_word();
        push(req);
        repeat (2) @(negedge clk);
    endtask

    task automatic direct_check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual att_left=%h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        model_reset();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        push("R1 reset defaults");
        repeat (2) @(negedge clk);

        // R5: playback fields
        write_word(mk(2'd2, {4'b0110, 2'b10, 1'b1, 1'b1, 1'b0}), "R5 playback fields");
        // R6: interface fields
        write_word(mk(2'd3, {1'b1, 2'b01, 2'b10, 1'b1, 1'b0, 1'b1, 1'b1}), "R6 interface fields");
        // R4: load bit gating
        write_word(mk(2'd0, 9'h040), "R4 left load bit clear");
        write_word(mk(2'd0, 9'h140), "R4 left load bit set");
        write_word(mk(2'd1, 9'h022), "R4 right load bit clear");
        write_word(mk(2'd1, 9'h122), "R4 right load bit set");
        // R3: reserved upper bits ignored
        write_word({5'b11111, 2'd1, 9'h133}, "R3 upper bits ignored");
        write_word({5'b10101, 2'd2, 9'h0A1}, "R3 address selects playback");

        // R2: full word without latch changes nothing, then latch commits it
        send_bits({16'h0000, mk(2'd0, 9'h101)}, 16);
        repeat (6) @(negedge clk);
        push("R2 no latch no change");
        repeat (2) @(negedge clk);
        latch_word();
        push("R2 latch commits");
        repeat (2) @(negedge clk);

        // R8: extra bits before the word
        send_bits(32'h0000000F, 4);
        write_word(mk(2'd1, 9'h15A), "R8 twenty bits");
        // R8: fewer bits, older bits fill the top
        write_word(mk(2'd3, 9'h1C5), "R8 setup");
        send_bits(32'h0000002D, 8);
        latch_word();
        push("R8 eight bits");
        repeat (2) @(negedge clk);
        write_word(mk(2'd3, 9'h000), "R8 cleanup");

        // R7: common attenuation
        write_word(mk(2'd3, 9'h004), "R7 common on");
        write_word(mk(2'd1, 9'h177), "R7 right load while common");
        write_word(mk(2'd3, 9'h000), "R7 common off");

        // R9: reserved codes stored
        write_word(mk(2'd2, 9'h138), "R9 reserved word length");
        write_word(mk(2'd3, 9'h0F0), "R9 reserved rate codes");

        // R10: exact commit cycle
        send_bits({16'h0000, mk(2'd0, 9'h110)}, 16);
        repeat (2) @(negedge clk);
        ctl_latch = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        direct_check("R10 two edges still old", att_left, m_al);
        @(posedge clk);
        @(negedge clk);
        direct_check("R10 third edge new", att_left, 8'h10);
        repeat (2) @(negedge clk);
        ctl_latch = 1'b0;
        repeat (3) @(negedge clk);
        model_apply(hist);
        push("R10 settled");
        repeat (2) @(negedge clk);

        // R1: reset again mid-run
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
        push("R1 reset again");
        repeat (3) @(negedge clk);

        summary();
        $finish;
    end
endmodule